// File: doc/BRIEF.md
# Victim Line Buffer

This block is a four-line, fully associative store that sits next to a direct-mapped cache. It only ever receives lines that the cache has just thrown out. The cache keeps its own single-cycle hit path, and the buffer is consulted only when the cache misses.

On a cache miss, the controller presents the missing line address on the lookup port. A match returns the whole line in the same cycle, so the request never reaches the next memory level. The controller then issues a swap. The swap moves the matching line out toward the cache, and in the same clock edge the line the cache displaced takes over the freed entry.

When the lookup misses, the request goes down the hierarchy. The line the cache evicts is then written through the insert port. When every entry is occupied, the insert overwrites the entry that was written longest ago. Each entry keeps the complete line address (cache tag and index together), because the buffer has no index of its own.

Top module: `victim_buf`

## Requirements
- R1: After a synchronous reset all entries are empty, and no lookup address hits.
- R2: When lookup_valid is high and a valid entry holds exactly lookup_addr, lookup_hit is 1 and lookup_line carries that entry's data in the same cycle, with no register on the path.
- R3: Up to four distinct lines inserted after reset all remain retrievable through the lookup port.
- R4: An insert of a new address into a full buffer overwrites the entry whose last write (insert or swap refill) is the oldest. All other lines stay.
- R5: An insert whose address is already held replaces that entry's data in place. It evicts no other line, and an address is never held twice.
- R6: A swap request whose swap_addr hits gives swap_ack=1 one cycle later, with the matching line on swap_line. From that edge on, swap_addr no longer hits, and the displaced line (swap_out_addr, swap_out_line) hits when swap_out_valid was 1. Swap and insert are never requested in the same cycle.
- R7: A swap request whose address misses gives swap_miss=1 one cycle later and leaves every stored line unchanged.
- R8: If insert and lookup name the same address in the same cycle, the lookup hits and returns the insert data.
- R9: A swap whose displaced line is marked invalid leaves the freed entry empty. The next insert of a new address fills that entry and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | 12 | Line address to look up |
| lookup_hit | output | 1 | Lookup found the line (combinational) |
| lookup_line | output | 64 | Data of the found line |
| ins_valid | input | 1 | Write an evicted line into the buffer |
| ins_addr | input | 12 | Line address of the evicted line |
| ins_line | input | 64 | Data of the evicted line |
| swap_req | input | 1 | Request a swap with the cache |
| swap_addr | input | 12 | Line address the cache wants back |
| swap_out_valid | input | 1 | The cache line being displaced is valid |
| swap_out_addr | input | 12 | Line address of the displaced cache line |
| swap_out_line | input | 64 | Data of the displaced cache line |
| swap_ack | output | 1 | Swap done, one cycle after the request |
| swap_miss | output | 1 | Swap address not held, one cycle after the request |
| swap_line | output | 64 | Line handed back to the cache, valid with swap_ack |

## Verification
A corrupted tag or valid bit shows on the lookup port in the very next cycle that names the address, as a missing hit, a false hit or wrong data. A fault in the write-age ordering stays hidden until the buffer is full. It then shows on the next insert of a new address, as the wrong line disappearing. The random stimulus uses a small address pool so that full-buffer replacement, in-place overwrite and swap refills happen often. A fault in the swap path shows one cycle after the request, on swap_ack, swap_miss or swap_line.

// File: rtl/vb_pkg.sv
package vb_pkg;

    parameter int ADDR_W = 12;
    parameter int LINE_W = 64;
    parameter int DEPTH  = 4;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef logic [ADDR_W-1:0] laddr_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DEPTH-1:0]  vec_t;

    typedef struct packed {
        logic   vld;
        laddr_t tag;
        line_t  data;
    } entry_t;

    // index of the set bit of a one-hot vector (0 when empty)
    function automatic idx_t oh_to_idx(vec_t oh);
        idx_t r;
        r = '0;
        for (int i = 0; i < DEPTH; i++)
            if (oh[i]) r = r | idx_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match
    import vb_pkg::*;
(
    input  entry_t [DEPTH-1:0] ents,
    input  laddr_t             addr,
    output vec_t               hit
);
    // one comparator per entry, all in parallel
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = ents[g].vld && (ents[g].tag == addr);
    end
endmodule

// File: rtl/vb_rank.sv
module vb_rank
    import vb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  idx_t wr_idx,
    output idx_t oldest
);
    // rank 0 = most recently written, DEPTH-1 = oldest write
    idx_t [DEPTH-1:0] rank;
    vec_t             is_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) rank[i] <= idx_t'(i);
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (idx_t'(i) == wr_idx)
                    rank[i] <= '0;
                else if (rank[i] < rank[wr_idx])
                    rank[i] <= rank[i] + idx_t'(1);
            end
        end
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < DEPTH; i++) begin
            is_old[i] = (rank[i] == idx_t'(DEPTH-1));
            if (is_old[i]) oldest = idx_t'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $onehot(is_old)); // R4

endmodule

// File: rtl/vb_target.sv
module vb_target
    import vb_pkg::*;
(
    input  vec_t vld,
    input  vec_t same,
    input  idx_t oldest,
    output idx_t tgt
);
    // priority: same address, then lowest empty slot, then oldest write
    always_comb begin
        tgt = oldest;
        for (int i = DEPTH-1; i >= 0; i--)
            if (!vld[i]) tgt = idx_t'(i);
        if (|same) tgt = oh_to_idx(same);
    end
endmodule

// File: rtl/victim_buf.sv
module victim_buf
    import vb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lookup_valid,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic               lookup_hit,
    output logic [LINE_W-1:0]  lookup_line,
    input  logic               ins_valid,
    input  logic [ADDR_W-1:0]  ins_addr,
    input  logic [LINE_W-1:0]  ins_line,
    input  logic               swap_req,
    input  logic [ADDR_W-1:0]  swap_addr,
    input  logic               swap_out_valid,
    input  logic [ADDR_W-1:0]  swap_out_addr,
    input  logic [LINE_W-1:0]  swap_out_line,
    output logic               swap_ack,
    output logic               swap_miss,
    output logic [LINE_W-1:0]  swap_line
);
    entry_t [DEPTH-1:0] ents;
    vec_t   lk_hits, sw_hits, in_hits, vld;
    idx_t   oldest, ins_tgt, wr_idx;
    line_t  lk_arr, sw_arr;
    logic   fwd, sw_do, ins_do, wr_en;

    vb_match u_lk (.ents(ents), .addr(lookup_addr), .hit(lk_hits));
    vb_match u_sw (.ents(ents), .addr(swap_addr),   .hit(sw_hits));
    vb_match u_in (.ents(ents), .addr(ins_addr),    .hit(in_hits));

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld[g] = ents[g].vld;
    end

    vb_target u_tgt (.vld(vld), .same(in_hits), .oldest(oldest), .tgt(ins_tgt));

    assign sw_do  = swap_req && (|sw_hits);
    assign ins_do = ins_valid && !swap_req;
    assign wr_en  = sw_do || ins_do;
    assign wr_idx = sw_do ? oh_to_idx(sw_hits) : ins_tgt;

    vb_rank u_rank (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .oldest(oldest));

    // data muxes driven by the one-hot match vectors
    always_comb begin
        lk_arr = '0;
        sw_arr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            lk_arr = lk_arr | ({LINE_W{lk_hits[i]}} & ents[i].data);
            sw_arr = sw_arr | ({LINE_W{sw_hits[i]}} & ents[i].data);
        end
    end

    // a line being inserted this cycle is visible to the lookup at once
    assign fwd         = ins_valid && (ins_addr == lookup_addr);
    assign lookup_hit  = lookup_valid && (fwd || (|lk_hits));
    assign lookup_line = fwd ? ins_line : lk_arr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            swap_ack  <= 1'b0;
            swap_miss <= 1'b0;
            swap_line <= '0;
        end else begin
            swap_ack  <= sw_do;
            swap_miss <= swap_req && !(|sw_hits);
            if (sw_do) begin
                swap_line      <= sw_arr;
                ents[wr_idx]   <= '{vld: swap_out_valid, tag: swap_out_addr, data: swap_out_line};
            end else if (ins_do) begin
                ents[wr_idx]   <= '{vld: 1'b1, tag: ins_addr, data: ins_line};
            end
        end
    end

    AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hits)); // R5
    AST_SWAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(swap_ack && swap_miss)); // R6
    AST_SWAP_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $past(swap_req) |-> (swap_ack || swap_miss)); // R7
    AST_NO_SWAP_WITH_INS: assert property (@(posedge clk) disable iff (rst)
        !(swap_req && ins_valid)); // R6

endmodule

// File: tb/sim_victim_buf.sv
`timescale 1ns/1ps
module sim_victim_buf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_valid = 0, ins_valid = 0, swap_req = 0, swap_out_valid = 0;
    logic [11:0] lookup_addr = 0, ins_addr = 0, swap_addr = 0, swap_out_addr = 0;
    logic [63:0] ins_line = 0, swap_out_line = 0;
    logic        lookup_hit, swap_ack, swap_miss;
    logic [63:0] lookup_line, swap_line;

    always #2.5 clk = ~clk;

    victim_buf u0 (.*);

    int nchk = 0, nfail = 0;
    bit done = 0;

    // reference model: slots with write stamps
    bit          mv[4];
    logic [11:0] ma[4];
    logic [63:0] md[4];
    int          ms[4];
    int          stamp = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int mfind(logic [11:0] a);
        for (int i = 0; i < 4; i++) if (mv[i] && ma[i] == a) return i;
        return -1;
    endfunction

    function automatic int mtarget(logic [11:0] a);
        int f, best;
        f = mfind(a);
        if (f >= 0) return f;
        for (int i = 0; i < 4; i++) if (!mv[i]) return i;
        best = 0;
        for (int i = 1; i < 4; i++) if (ms[i] < ms[best]) best = i;
        return best;
    endfunction

    // one clock of stimulus; inputs set just after a falling edge
    task automatic drive(bit lv, logic [11:0] la, bit iv, logic [11:0] ia, logic [63:0] id,
                         bit sr, logic [11:0] sa, bit ev, logic [11:0] ea, logic [63:0] ed);
        bit fw, eh, ea_k, em;
        int f, t;
        logic [63:0] el, exd;
        lookup_valid = lv; lookup_addr = la;
        ins_valid = iv; ins_addr = ia; ins_line = id;
        swap_req = sr; swap_addr = sa; swap_out_valid = ev; swap_out_addr = ea; swap_out_line = ed;
        #1;
        fw = iv && (ia == la);
        f  = mfind(la);
        eh = lv && (fw || f >= 0);
        exd = fw ? id : (f >= 0 ? md[f] : 64'h0);
        chk(lookup_hit == eh, fw ? "R8 lookup hit" : "R2 lookup hit", 64'(lookup_hit), 64'(eh));
        if (eh) chk(lookup_line == exd, fw ? "R8 lookup data" : "R2 lookup data", lookup_line, exd);
        ea_k = 0; em = 0; el = 0;
        if (sr) begin
            f = mfind(sa);
            if (f >= 0) begin
                ea_k = 1; el = md[f];
                mv[f] = ev; ma[f] = ea; md[f] = ed; ms[f] = ++stamp;
            end else em = 1;
        end else if (iv) begin
            t = mtarget(ia);
            mv[t] = 1; ma[t] = ia; md[t] = id; ms[t] = ++stamp;
        end
        @(negedge clk);
        ins_valid = 0; swap_req = 0;
        chk(swap_ack == ea_k, "R6 swap_ack", 64'(swap_ack), 64'(ea_k));
        chk(swap_miss == em, "R7 swap_miss", 64'(swap_miss), 64'(em));
        if (ea_k) chk(swap_line == el, "R6 swap_line", swap_line, el);
    endtask

    task automatic probe(logic [11:0] a, bit eh, logic [63:0] ed, string req);
        lookup_valid = 1; lookup_addr = a; #1;
        chk(lookup_hit == eh, req, 64'(lookup_hit), 64'(eh));
        if (eh) chk(lookup_line == ed, req, lookup_line, ed);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    function automatic logic [63:0] dv(int k);
        return {32'hD0D0_0000 + 32'(k), 32'(k) * 32'h9E37_79B9};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin mv[i] = 0; ms[i] = 0; ma[i] = 0; md[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty after reset
        for (int a = 0; a < 4; a++) probe(12'(a), 0, 0, "R1 empty after reset");
        // R3: fill four lines
        for (int k = 0; k < 4; k++) drive(0, 0, 1, 12'h100 + 12'(k), dv(k), 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) probe(12'h100 + 12'(k), 1, dv(k), "R3 four lines held");
        // R4: fifth line evicts the oldest write (0x100)
        drive(0, 0, 1, 12'h104, dv(4), 0, 0, 0, 0, 0);
        probe(12'h100, 0, 0, "R4 oldest evicted");
        probe(12'h104, 1, dv(4), "R4 new line held");
        probe(12'h101, 1, dv(1), "R4 others kept");
        // R5: rewrite of a held address in place
        drive(0, 0, 1, 12'h102, dv(20), 0, 0, 0, 0, 0);
        probe(12'h102, 1, dv(20), "R5 data replaced");
        probe(12'h101, 1, dv(1), "R5 no eviction");
        // R6: swap 0x103 out, 0x200 in
        drive(0, 0, 0, 0, 0, 1, 12'h103, 1, 12'h200, dv(30));
        probe(12'h103, 0, 0, "R6 swapped line gone");
        probe(12'h200, 1, dv(30), "R6 displaced line held");
        // R7: swap miss
        drive(0, 0, 0, 0, 0, 1, 12'h3FF, 1, 12'h201, dv(31));
        probe(12'h201, 0, 0, "R7 nothing written");
        probe(12'h104, 1, dv(4), "R7 contents kept");
        // R9: swap with invalid displaced line frees an entry
        drive(0, 0, 0, 0, 0, 1, 12'h101, 0, 12'h202, dv(32));
        drive(0, 0, 1, 12'h300, dv(33), 0, 0, 0, 0, 0);
        probe(12'h104, 1, dv(4), "R9 free slot used, no eviction");
        probe(12'h300, 1, dv(33), "R9 inserted line held");
        // R8: same-cycle forward
        drive(1, 12'h301, 1, 12'h301, dv(34), 0, 0, 0, 0, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [11:0] a, b, e;
            op = int'($urandom % 4);
            a  = 12'($urandom % 16);
            b  = ($urandom % 4 == 0) ? a : 12'($urandom % 16);
            if (op == 0)
                drive(1, b, 1, a, {$urandom, $urandom}, 0, 0, 0, 0, 0);
            else if (op == 1) begin
                do e = 12'($urandom % 16); while (mfind(e) >= 0 || e == a);
                drive(1, b, 0, 0, 0, 1, a, 1'($urandom % 4 != 0), e, {$urandom, $urandom});
            end else
                drive(1, b, 0, 0, 0, 0, 0, 0, 0, 0);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule